// File: doc/BRIEF.md
# Dual-Port Banked Data Array Arbiter

This block sits in front of a data-cache array that is split into eight banks, each one 16 bytes (128 bits) wide. Two request ports present 128-bit loads and stores in the same cycle. The block finds the bank each address selects and compares the two. When the banks differ, both requests go into the array together. When they are the same, one port is held back and must replay its request the next cycle. Loads return their data a fixed three cycles after acceptance, on one of two response lanes. Each response is tagged with the port it belongs to, so a requester can match completions that arrive out of order after a replay.

Stores always write the array, so a store that misses still allocates the chunk. Each store marks its 64-byte line dirty. The dirty bit is reported and cleared only when the line is evicted, which is the point where write-back traffic to the next level happens. Coherence state, miss handling and error correction belong to neighbouring logic.

Each request port uses valid/ready. A request is taken on a clock edge where both valid and ready are high. While valid is high and ready is low, the requester must hold the request and keep its address, write flag and data stable. Ready may depend on both ports' valid signals in the same cycle. The response lanes and the dirty-mark outputs have no back-pressure. The eviction query is a plain one-cycle strobe.

Top module: `dcb_bank_arbiter`

## Requirements
- R1: The bank of a request is address bits [6:4]. When both ports are valid and their banks differ, both ready outputs are high in that cycle.
- R2: When both ports are valid and select the same bank, only one port's ready is high, and replay is high for the other port (replay bit 0 = port 0, bit 1 = port 1). This holds even when both addresses fall in the same 16-byte chunk. Out of reset, port 0 wins such a conflict.
- R3: In the cycle after port 1 was valid but not ready, port 1 is ready. If that cycle is again a conflict, port 0 is the one that gets replay.
- R4: A load accepted in cycle c gives a valid response in cycle c+3. The data is the last value stored to the same bank and row, which are address bits [11:7] and [6:4]. Address bits [3:0] are ignored.
- R5: Lane 0 carries port 0's load when port 0 is accepted. It carries port 1's load when only port 1 is accepted. Lane 1 carries port 1's load when both ports are accepted. rsp_port holds the port number (0 or 1) for each lane.
- R6: An accepted store produces no response.
- R7: A store writes the array whether or not the chunk held valid data before. A load accepted in the cycle after that store returns the new data.
- R8: A store accepted in cycle c pulses dmark_valid on the same lane index as its response lane would use, in cycle c+2. dmark_line then carries its line number, which is address bits [11:6].
- R9: An eviction strobe in cycle e gives evict_done in cycle e+1. evict_dirty is 1 if the line was marked dirty since its last eviction, and 0 otherwise. The line's dirty bit is then cleared.
- R10: If a store's dirty mark and an eviction of the same line fall on the same clock edge, the eviction reports the old state and the line stays dirty.
- R11: While reset is asserted, rsp_valid, dmark_valid and evict_done are 0, and all dirty bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| p0_valid | input | 1 | Port 0 request valid |
| p0_ready | output | 1 | Port 0 request accepted this cycle if valid |
| p0_we | input | 1 | Port 0 store (1) or load (0) |
| p0_addr | input | ADDR_W | Port 0 byte address |
| p0_wdata | input | DATA_W | Port 0 store data |
| p1_valid | input | 1 | Port 1 request valid |
| p1_ready | output | 1 | Port 1 request accepted this cycle if valid |
| p1_we | input | 1 | Port 1 store (1) or load (0) |
| p1_addr | input | ADDR_W | Port 1 byte address |
| p1_wdata | input | DATA_W | Port 1 store data |
| replay | output | 2 | Per port: valid request lost a bank conflict |
| rsp_valid | output | 2 | Per lane: load data valid |
| rsp_port | output | 2 | Per lane: port the response belongs to |
| rsp_data | output | 2 x DATA_W | Per lane: load data |
| dmark_valid | output | 2 | Per lane: a store marked a line dirty |
| dmark_line | output | 2 x LINE_W | Per lane: marked line number |
| evict_valid | input | 1 | Eviction query strobe |
| evict_line | input | LINE_W | Line being evicted |
| evict_done | output | 1 | Eviction answer valid |
| evict_dirty | output | 1 | Evicted line needs write-back |

## Verification
The bench drives a sequence of paired loads that alternates between disjoint banks and colliding banks. Some pairs collide in the same chunk, and some collisions follow a lost conflict directly. This catches an arbiter that compares whole addresses instead of bank bits, one that lets port 1 starve, and one that forgets to clear its priority flag. Directed tests check the response lane, the port tag and the exact response cycle for a replayed port 1. They also check that a store is visible to a load issued one cycle later, that stores produce no response, and that the low address bits are ignored. The eviction tests cover a clean line, a dirty line, and a store mark that lands on the same edge as an eviction. A tracker that clears after setting on that edge would lose the dirty line and skip its write-back.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  localparam int NPORT = 2;
  typedef enum logic {PORT0 = 1'b0, PORT1 = 1'b1} port_id_e;
endpackage

// File: rtl/dcb_bank_decode.sv
module dcb_bank_decode #(
  parameter int ADDR_W     = 12,
  parameter int OFF_W      = 4,
  parameter int BANK_W     = 3,
  parameter int LINE_OFF_W = 6,
  localparam int ROW_W     = ADDR_W - OFF_W - BANK_W,
  localparam int LINE_W    = ADDR_W - LINE_OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [LINE_W-1:0] line
);
  assign bank = addr[OFF_W +: BANK_W];
  assign row  = addr[ADDR_W-1 -: ROW_W];
  assign line = addr[ADDR_W-1 -: LINE_W];
endmodule

// File: rtl/dcb_arbiter.sv
module dcb_arbiter #(
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v0,
  input  logic              v1,
  input  logic [BANK_W-1:0] bank0,
  input  logic [BANK_W-1:0] bank1,
  output logic              ready0,
  output logic              ready1,
  output logic [1:0]        replay
);
  logic clash;
  logic p1_first;

  // a clash is any pair of valid requests on one bank, chunk ignored
  assign clash  = v0 && v1 && (bank0 == bank1);
  assign ready0 = !(clash && p1_first);
  assign ready1 = !(clash && !p1_first);
  assign replay = {v1 && !ready1, v0 && !ready0};

  // port 1 gets the next clash only right after it lost one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) p1_first <= 1'b0;
    else        p1_first <= clash && !p1_first;
  end
endmodule

// File: rtl/dcb_array_pipe.sv
module dcb_array_pipe
  import dcb_pkg::*;
#(
  parameter int N_BANK = 8,
  parameter int DATA_W = 128,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 5,
  parameter int LINE_W = 6,
  localparam int ROWS  = 1 << ROW_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPORT-1:0]             in_vld,
  input  logic [NPORT-1:0]             in_we,
  input  port_id_e                     in_port [NPORT],
  input  logic [NPORT-1:0][BANK_W-1:0] in_bank,
  input  logic [NPORT-1:0][ROW_W-1:0]  in_row,
  input  logic [NPORT-1:0][LINE_W-1:0] in_line,
  input  logic [NPORT-1:0][DATA_W-1:0] in_wdata,
  output logic [NPORT-1:0]             st_mark,
  output logic [NPORT-1:0][LINE_W-1:0] st_line,
  output logic [NPORT-1:0]             rsp_valid,
  output logic [NPORT-1:0]             rsp_port,
  output logic [NPORT-1:0][DATA_W-1:0] rsp_data
);
  logic [DATA_W-1:0] mem [N_BANK][ROWS];

  logic [NPORT-1:0]             s1_vld, s1_we;
  port_id_e                     s1_port [NPORT];
  logic [NPORT-1:0][BANK_W-1:0] s1_bank;
  logic [NPORT-1:0][ROW_W-1:0]  s1_row;
  logic [NPORT-1:0][LINE_W-1:0] s1_line;
  logic [NPORT-1:0][DATA_W-1:0] s1_wdata;

  logic [NPORT-1:0]             s2_vld;
  port_id_e                     s2_port [NPORT];
  logic [NPORT-1:0][DATA_W-1:0] s2_data;

  // stage 1: capture, stage 2: array access, stage 3: output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld    <= '0;
      s1_we     <= '0;
      s2_vld    <= '0;
      rsp_valid <= '0;
    end else begin
      s1_vld    <= in_vld;
      s1_we     <= in_we;
      s2_vld    <= s1_vld & ~s1_we;
      rsp_valid <= s2_vld;
    end
  end

  for (genvar ln = 0; ln < NPORT; ln++) begin : g_lane
    always_ff @(posedge clk) begin
      s1_port[ln]  <= in_port[ln];
      s1_bank[ln]  <= in_bank[ln];
      s1_row[ln]   <= in_row[ln];
      s1_line[ln]  <= in_line[ln];
      s1_wdata[ln] <= in_wdata[ln];
      s2_port[ln]  <= s1_port[ln];
      s2_data[ln]  <= mem[s1_bank[ln]][s1_row[ln]];
      rsp_port[ln] <= s2_port[ln];
      rsp_data[ln] <= s2_data[ln];
    end
    assign st_mark[ln] = s1_vld[ln] && s1_we[ln];
    assign st_line[ln] = s1_line[ln];
  end

  // lanes never share a bank, so the two writes never collide
  always_ff @(posedge clk) begin
    for (int ln = 0; ln < NPORT; ln++) begin
      if (s1_vld[ln] && s1_we[ln]) mem[s1_bank[ln]][s1_row[ln]] <= s1_wdata[ln];
    end
  end
endmodule

// File: rtl/dcb_dirty_track.sv
module dcb_dirty_track
  import dcb_pkg::*;
#(
  parameter int LINE_W = 6,
  localparam int LINES = 1 << LINE_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPORT-1:0]             st_mark,
  input  logic [NPORT-1:0][LINE_W-1:0] st_line,
  input  logic                         evict_valid,
  input  logic [LINE_W-1:0]            evict_line,
  output logic [NPORT-1:0]             dmark_valid,
  output logic [NPORT-1:0][LINE_W-1:0] dmark_line,
  output logic                         evict_done,
  output logic                         evict_dirty
);
  logic [LINES-1:0] dirty, dirty_n;

  // clear first, then set: a store landing with the eviction wins
  always_comb begin
    dirty_n = dirty;
    if (evict_valid) dirty_n[evict_line] = 1'b0;
    for (int ln = 0; ln < NPORT; ln++) begin
      if (st_mark[ln]) dirty_n[st_line[ln]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty       <= '0;
      dmark_valid <= '0;
      dmark_line  <= '0;
      evict_done  <= 1'b0;
      evict_dirty <= 1'b0;
    end else begin
      dirty       <= dirty_n;
      dmark_valid <= st_mark;
      dmark_line  <= st_line;
      evict_done  <= evict_valid;
      evict_dirty <= evict_valid && dirty[evict_line];
    end
  end
endmodule

// File: rtl/dcb_bank_arbiter.sv
module dcb_bank_arbiter
  import dcb_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 128,
  parameter int N_BANK     = 8,
  parameter int LINE_BYTES = 64,
  localparam int OFF_W      = $clog2(DATA_W / 8),
  localparam int BANK_W     = $clog2(N_BANK),
  localparam int ROW_W      = ADDR_W - OFF_W - BANK_W,
  localparam int LINE_OFF_W = $clog2(LINE_BYTES),
  localparam int LINE_W     = ADDR_W - LINE_OFF_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   p0_valid,
  output logic                   p0_ready,
  input  logic                   p0_we,
  input  logic [ADDR_W-1:0]      p0_addr,
  input  logic [DATA_W-1:0]      p0_wdata,
  input  logic                   p1_valid,
  output logic                   p1_ready,
  input  logic                   p1_we,
  input  logic [ADDR_W-1:0]      p1_addr,
  input  logic [DATA_W-1:0]      p1_wdata,
  output logic [1:0]             replay,
  output logic [1:0]             rsp_valid,
  output logic [1:0]             rsp_port,
  output logic [1:0][DATA_W-1:0] rsp_data,
  output logic [1:0]             dmark_valid,
  output logic [1:0][LINE_W-1:0] dmark_line,
  input  logic                   evict_valid,
  input  logic [LINE_W-1:0]      evict_line,
  output logic                   evict_done,
  output logic                   evict_dirty
);
  logic [NPORT-1:0][ADDR_W-1:0] p_addr;
  logic [NPORT-1:0][BANK_W-1:0] p_bank;
  logic [NPORT-1:0][ROW_W-1:0]  p_row;
  logic [NPORT-1:0][LINE_W-1:0] p_line;

  assign p_addr = {p1_addr, p0_addr};

  for (genvar p = 0; p < NPORT; p++) begin : g_dec
    dcb_bank_decode #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BANK_W(BANK_W), .LINE_OFF_W(LINE_OFF_W)
    ) u_dec (
      .addr(p_addr[p]), .bank(p_bank[p]), .row(p_row[p]), .line(p_line[p])
    );
  end

  dcb_arbiter #(.BANK_W(BANK_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .v0(p0_valid), .v1(p1_valid),
    .bank0(p_bank[0]), .bank1(p_bank[1]),
    .ready0(p0_ready), .ready1(p1_ready), .replay(replay)
  );

  logic g0, g1;
  assign g0 = p0_valid && p0_ready;
  assign g1 = p1_valid && p1_ready;

  // lane 0: port 0 if granted, else port 1; lane 1: port 1 beside port 0
  logic [NPORT-1:0]             l_vld, l_we;
  port_id_e                     l_port [NPORT];
  logic [NPORT-1:0][BANK_W-1:0] l_bank;
  logic [NPORT-1:0][ROW_W-1:0]  l_row;
  logic [NPORT-1:0][LINE_W-1:0] l_line;
  logic [NPORT-1:0][DATA_W-1:0] l_wdata;

  always_comb begin
    l_vld[0]   = g0 || g1;
    l_we[0]    = g0 ? p0_we : p1_we;
    l_port[0]  = g0 ? PORT0 : PORT1;
    l_bank[0]  = g0 ? p_bank[0] : p_bank[1];
    l_row[0]   = g0 ? p_row[0] : p_row[1];
    l_line[0]  = g0 ? p_line[0] : p_line[1];
    l_wdata[0] = g0 ? p0_wdata : p1_wdata;
    l_vld[1]   = g0 && g1;
    l_we[1]    = p1_we;
    l_port[1]  = PORT1;
    l_bank[1]  = p_bank[1];
    l_row[1]   = p_row[1];
    l_line[1]  = p_line[1];
    l_wdata[1] = p1_wdata;
  end

  logic [NPORT-1:0]             st_mark;
  logic [NPORT-1:0][LINE_W-1:0] st_line;

  dcb_array_pipe #(
    .N_BANK(N_BANK), .DATA_W(DATA_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .LINE_W(LINE_W)
  ) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_vld(l_vld), .in_we(l_we), .in_port(l_port), .in_bank(l_bank),
    .in_row(l_row), .in_line(l_line), .in_wdata(l_wdata),
    .st_mark(st_mark), .st_line(st_line),
    .rsp_valid(rsp_valid), .rsp_port(rsp_port), .rsp_data(rsp_data)
  );

  dcb_dirty_track #(.LINE_W(LINE_W)) u_dirty (
    .clk(clk), .rst_n(rst_n), .st_mark(st_mark), .st_line(st_line),
    .evict_valid(evict_valid), .evict_line(evict_line),
    .dmark_valid(dmark_valid), .dmark_line(dmark_line),
    .evict_done(evict_done), .evict_dirty(evict_dirty)
  );
endmodule

// File: rtl/dcb_bank_arbiter_chk.sv
module dcb_bank_arbiter_chk #(
  parameter int ADDR_W   = 12,
  parameter int BANK_LSB = 4,
  parameter int BANK_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              p0_valid,
  input logic              p0_ready,
  input logic              p0_we,
  input logic [ADDR_W-1:0] p0_addr,
  input logic              p1_valid,
  input logic              p1_ready,
  input logic [ADDR_W-1:0] p1_addr,
  input logic [1:0]        rsp_valid,
  input logic              evict_valid,
  input logic              evict_done
);
  logic same_bank;
  assign same_bank = p0_addr[BANK_LSB +: BANK_W] == p1_addr[BANK_LSB +: BANK_W];

  assert_both_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_valid && p1_valid && !same_bank) |-> (p0_ready && p1_ready));

  assert_one_winner_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_valid && p1_valid && same_bank) |-> ($countones({p0_ready, p1_ready}) == 1));

  assert_no_starve_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(p1_valid && !p1_ready) && p1_valid) |-> p1_ready);

  assert_load_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(p0_valid && p0_ready && !p0_we, 3) |-> rsp_valid[0]);

  assert_store_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(p0_valid && p0_ready && p0_we && !p1_valid, 3) |-> !rsp_valid[0]);

  assert_evict_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |=> evict_done);
endmodule

bind dcb_bank_arbiter dcb_bank_arbiter_chk #(
  .ADDR_W(ADDR_W), .BANK_LSB(OFF_W), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .p0_valid(p0_valid), .p0_ready(p0_ready),
  .p0_we(p0_we), .p0_addr(p0_addr), .p1_valid(p1_valid), .p1_ready(p1_ready),
  .p1_addr(p1_addr), .rsp_valid(rsp_valid), .evict_valid(evict_valid),
  .evict_done(evict_done)
);

// File: tb/tb_dcb_bank_arbiter.sv
module tb_dcb_bank_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic         p0_valid = 0, p0_we = 0, p1_valid = 0, p1_we = 0;
  logic [11:0]  p0_addr = 0, p1_addr = 0;
  logic [127:0] p0_wdata = 0, p1_wdata = 0;
  logic         p0_ready, p1_ready;
  logic [1:0]   replay, rsp_valid, rsp_port, dmark_valid;
  logic [1:0][127:0] rsp_data;
  logic [1:0][5:0]   dmark_line;
  logic         evict_valid = 0;
  logic [5:0]   evict_line = 0;
  logic         evict_done, evict_dirty;

  dcb_bank_arbiter dut (.*);

  int tests = 0, fails = 0;

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] mk(input int row, input int bank, input int off);
    return {row[4:0], bank[2:0], off[3:0]};
  endfunction

  task automatic put(input logic v0, input logic w0, input logic [11:0] a0, input logic [127:0] d0,
                     input logic v1, input logic w1, input logic [11:0] a1, input logic [127:0] d1);
    p0_valid = v0; p0_we = w0; p0_addr = a0; p0_wdata = d0;
    p1_valid = v1; p1_we = w1; p1_addr = a1; p1_wdata = d1;
  endtask

  task automatic idle();
    put(0, 0, 12'h0, '0, 0, 0, 12'h0, '0);
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  // {v0, v1, bank0[2:0], bank1[2:0], ready0, ready1}
  localparam int NV = 10;
  localparam logic [9:0] VEC [NV] = '{
    {1'b1, 1'b1, 3'd0, 3'd1, 1'b1, 1'b1},
    {1'b1, 1'b1, 3'd2, 3'd2, 1'b1, 1'b0},
    {1'b1, 1'b1, 3'd2, 3'd2, 1'b0, 1'b1},
    {1'b1, 1'b1, 3'd5, 3'd5, 1'b1, 1'b0},
    {1'b1, 1'b1, 3'd3, 3'd4, 1'b1, 1'b1},
    {1'b1, 1'b1, 3'd3, 3'd3, 1'b1, 1'b0},
    {1'b0, 1'b1, 3'd6, 3'd6, 1'b1, 1'b1},
    {1'b1, 1'b0, 3'd7, 3'd7, 1'b1, 1'b1},
    {1'b1, 1'b1, 3'd7, 3'd0, 1'b1, 1'b1},
    {1'b1, 1'b1, 3'd4, 3'd4, 1'b1, 1'b0}
  };

  localparam logic [11:0] A = 12'h110;   // row 2, bank 1, line 4
  localparam logic [11:0] B = 12'h030;   // row 0, bank 3, line 0
  localparam logic [127:0] DA = 128'hA0A0_0001_A0A0_0002_A0A0_0003_A0A0_0004;
  localparam logic [127:0] DB = 128'hB0B0_0001_B0B0_0002_B0B0_0003_B0B0_0004;
  localparam logic [127:0] D2 = 128'hC3C3_5A5A_0F0F_F0F0_1234_5678_9ABC_DEF0;

  logic done = 1'b0;

  initial begin
    #(4 * 100000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle();
    nxt(); nxt();
    // R11: outputs quiet in reset
    check("R11 rsp_valid", rsp_valid, 2'b00);
    check("R11 dmark_valid", dmark_valid, 2'b00);
    check("R11 evict_done", evict_done, 1'b0);
    nxt();
    rst_n = 1'b1;

    // table: arbitration over a run of paired loads
    for (int i = 0; i < NV; i++) begin
      nxt();
      put(VEC[i][9], 0, mk(i % 4, int'(VEC[i][7:5]), 0), '0,
          VEC[i][8], 0, mk(i % 4, int'(VEC[i][4:2]), 0), '0);
      #1;
      check($sformatf("R1/R2/R3 vec%0d ready", i), {p0_ready, p1_ready}, VEC[i][1:0]);
      check($sformatf("R2 vec%0d replay", i), replay,
            {VEC[i][8] & ~VEC[i][0], VEC[i][9] & ~VEC[i][1]});
    end
    nxt(); idle();
    repeat (5) nxt();

    // stores on two banks: dirty marks two cycles later (R7, R8)
    put(1, 1, A, DA, 1, 1, B, DB);
    nxt(); idle();
    nxt();
    check("R8 dmark_valid", dmark_valid, 2'b11);
    check("R8 dmark_line lane0", dmark_line[0], 6'd4);
    check("R8 dmark_line lane1", dmark_line[1], 6'd0);
    nxt();
    check("R6 no response for stores", rsp_valid, 2'b00);

    // dual load with offsets: lanes, tags, data (R4, R5)
    put(0, 0, 12'h0, '0, 0, 0, 12'h0, '0);
    put(1, 0, B | 12'h9, '0, 1, 0, A | 12'h5, '0);
    nxt(); idle();
    nxt(); nxt();
    check("R4 dual rsp_valid", rsp_valid, 2'b11);
    check("R5 lane0 port", rsp_port[0], 1'b0);
    check("R5 lane1 port", rsp_port[1], 1'b1);
    check("R4 lane0 data", rsp_data[0], DB);
    check("R4 lane1 data", rsp_data[1], DA);
    nxt();

    // port 1 alone uses lane 0 (R5)
    put(0, 0, 12'h0, '0, 1, 0, A, '0);
    nxt(); idle();
    nxt(); nxt();
    check("R5 solo p1 rsp_valid", rsp_valid, 2'b01);
    check("R5 solo p1 tag", rsp_port[0], 1'b1);
    nxt();

    // store then load next cycle sees new data (R7)
    put(1, 1, A, D2, 0, 0, 12'h0, '0);
    nxt();
    put(1, 0, A, '0, 0, 0, 12'h0, '0);
    nxt(); idle();
    nxt();
    check("R6 store slot silent", rsp_valid, 2'b00);
    nxt();
    check("R7 load after store valid", rsp_valid, 2'b01);
    check("R7 load after store data", rsp_data[0], D2);
    nxt();

    // same-chunk conflict, port 1 replays (R2, R3, R4, R5)
    put(1, 0, A, '0, 1, 0, A | 12'h4, '0);
    #1;
    check("R2 same chunk ready", {p0_ready, p1_ready}, 2'b10);
    check("R2 same chunk replay", replay, 2'b10);
    nxt();
    put(0, 0, 12'h0, '0, 1, 0, A | 12'h4, '0);
    #1;
    check("R3 replayed p1 ready", p1_ready, 1'b1);
    nxt(); idle();
    nxt();
    check("R4 p0 after conflict valid", rsp_valid, 2'b01);
    check("R5 p0 after conflict tag", rsp_port[0], 1'b0);
    check("R4 p0 after conflict data", rsp_data[0], D2);
    nxt();
    check("R4 p1 replay valid", rsp_valid, 2'b01);
    check("R5 p1 replay tag", rsp_port[0], 1'b1);
    check("R4 p1 replay data", rsp_data[0], D2);
    nxt();

    // evictions (R9)
    evict_valid = 1; evict_line = 6'd4;
    nxt(); evict_valid = 0;
    check("R9 dirty evict done", evict_done, 1'b1);
    check("R9 dirty evict", evict_dirty, 1'b1);
    evict_valid = 1; evict_line = 6'd4;
    nxt(); evict_valid = 0;
    check("R9 cleared line", evict_dirty, 1'b0);
    evict_valid = 1; evict_line = 6'd20;
    nxt(); evict_valid = 0;
    check("R9 clean line done", evict_done, 1'b1);
    check("R9 clean line", evict_dirty, 1'b0);
    nxt();

    // store mark and eviction on the same edge (R10)
    put(1, 1, A, DA, 0, 0, 12'h0, '0);
    nxt(); idle();
    evict_valid = 1; evict_line = 6'd4;
    nxt();
    check("R10 evict reports old state", evict_dirty, 1'b0);
    evict_valid = 1; evict_line = 6'd4;
    nxt(); evict_valid = 0;
    check("R10 line stays dirty", evict_dirty, 1'b1);
    nxt(); nxt();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule